// File: doc/BRIEF.md
# Shared-Curve Interpolating Degamma Stage

This block applies one programmable transfer curve to the red, green and blue components of a pixel stream. It sits at the front of a colour pipeline, and its output feeds the first colour-conversion matrix. A sparse table of 33 breakpoints defines the curve. Each 10-bit input code is split into a segment index and a fraction, and the output is found by linear interpolation between the two breakpoints that bound the segment. The same table serves all three channels, and one pixel is accepted on every clock.

Software loads breakpoints through a simple address/data write port. The block expects the curve to be non-decreasing. A write that breaks this order against its stored neighbours is still stored, but it sets a sticky error flag. A bypass control sends pixels through unchanged, with the same fixed pipeline delay as the curve path.

Top module: `degam_lut`

## Requirements
- R1: The table holds breakpoints at write addresses 0 to 32. After reset, entry i holds min(i*2048, 65535). A write to any address from 33 to 63 changes nothing.
- R2: For input code c, the segment is s = c[9:5] and the fraction is f = c[4:0]. The output is P[s] + ((P[s+1]-P[s])*f + 16) >>> 5, using signed arithmetic, clamped to the range 0..65535.
- R3: An input of all ones (1023) gives exactly the segment-31 value for fraction 31. Breakpoint 32 is used only as the upper end of segment 31.
- R4: The same table serves all three channels. The three channels are processed in parallel and stay aligned in time.
- R5: out_valid equals in_valid delayed by exactly 3 clocks, and each output pixel appears 3 clocks after it is sampled.
- R6: When bypass is high at the sampling edge, each output channel equals its input code zero-extended to 16 bits, with the same 3-clock latency.
- R7: A write to address a sets mono_err on the next clock if the written value is below stored P[a-1] (for a>0) or above stored P[a+1] (for a<32). The value is stored regardless.
- R8: A pixel sampled on the same edge as a table write uses the old table. A pixel sampled on any later edge uses the new table.
- R9: Reset clears out_valid, the output channels and mono_err. Once set, mono_err stays high until reset.
- R10: When a segment's breakpoints are non-decreasing, the interpolated output lies between P[s] and P[s+1] inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Breakpoint write strobe |
| wr_addr | input | 6 | Breakpoint index |
| wr_data | input | 16 | Breakpoint value |
| mono_err | output | 1 | Sticky non-monotonic write flag |
| bypass | input | 1 | Pass pixels through unchanged |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 10 | Red input code |
| in_g | input | 10 | Green input code |
| in_b | input | 10 | Blue input code |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 16 | Red output |
| out_g | output | 16 | Green output |
| out_b | output | 16 | Blue output |

## Verification
A table write and a pixel lookup can both happen on the same clock edge. The pixel lookup reads the segment endpoints while the write port changes one of them. The bench provokes this by streaming codes from the low segments without a gap while it rewrites breakpoint 1 in the middle of the stream. Its model computes each pixel from the table as it stood before that cycle's write, and only then applies the write. Any pixel that picks up the new value too early, or keeps the old value too long, shows up as a mismatch in that channel. The same write cycles are also checked for the error flag, which is set only when the written value breaks order against its stored neighbours.

// File: rtl/degam_pkg.sv
package degam_pkg;

    localparam int DG_IN_W  = 10;
    localparam int DG_SEG_W = 5;
    localparam int DG_PT_W  = 16;
    localparam int DG_LANES = 3;

    typedef enum logic [1:0] {
        LANE_R = 2'd0,
        LANE_G = 2'd1,
        LANE_B = 2'd2
    } lane_e;

    // Reset curve: evenly spaced ramp, top entry saturated.
    function automatic logic [DG_PT_W-1:0] dg_reset_point(input int idx);
        longint v;
        v = longint'(idx) << (DG_PT_W - DG_SEG_W);
        if (v > ((longint'(1) << DG_PT_W) - 1))
            v = (longint'(1) << DG_PT_W) - 1;
        return DG_PT_W'(v);
    endfunction

endpackage

// File: rtl/degam_table.sv
module degam_table
    import degam_pkg::*;
#(
    parameter int SEG_W = DG_SEG_W,
    parameter int PT_W  = DG_PT_W,
    parameter int AW    = SEG_W + 1,
    parameter int NPTS  = (1 << SEG_W) + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [PT_W-1:0]            wr_data,
    output logic [NPTS-1:0][PT_W-1:0]  pts,
    output logic                       mono_err
);

    logic [NPTS-1:0] hit;
    logic [NPTS-1:0] viol;

    for (genvar gi = 0; gi < NPTS; gi++) begin : g_pt
        logic below_prev;
        logic above_next;
        assign hit[gi] = wr_en && (wr_addr == AW'(gi));
        if (gi > 0) begin : g_lo
            assign below_prev = wr_data < pts[gi-1];
        end else begin : g_lo0
            assign below_prev = 1'b0;
        end
        if (gi < NPTS - 1) begin : g_hi
            assign above_next = wr_data > pts[gi+1];
        end else begin : g_hi0
            assign above_next = 1'b0;
        end
        assign viol[gi] = below_prev || above_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPTS; i++)
                pts[i] <= dg_reset_point(i);
            mono_err <= 1'b0;
        end else begin
            for (int i = 0; i < NPTS; i++)
                if (hit[i]) pts[i] <= wr_data;
            if (|(hit & viol)) mono_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        mono_err |=> mono_err); // R9

    AST_ERR_ON_BAD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > AW'(0) && wr_addr < AW'(NPTS) && wr_data < pts[wr_addr - AW'(1)])
        |=> mono_err); // R7

    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr < AW'(NPTS)) |=> pts[$past(wr_addr)] == $past(wr_data)); // R7

endmodule

// File: rtl/degam_lane.sv
module degam_lane
    import degam_pkg::*;
#(
    parameter int IN_W  = DG_IN_W,
    parameter int SEG_W = DG_SEG_W,
    parameter int PT_W  = DG_PT_W,
    parameter int NPTS  = (1 << SEG_W) + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPTS-1:0][PT_W-1:0]  pts,
    input  logic                       in_vld,
    input  logic                       in_byp,
    input  logic [IN_W-1:0]            in_code,
    output logic                       out_vld,
    output logic [PT_W-1:0]            out_val
);

    localparam int FR_W = IN_W - SEG_W;
    localparam int DW   = PT_W + 1;
    localparam int PRW  = PT_W + FR_W + 2;
    localparam int SW   = PT_W + 2;

    typedef struct packed {
        logic              vld;
        logic              byp;
        logic [IN_W-1:0]   raw;
        logic [FR_W-1:0]   frac;
        logic [PT_W-1:0]   lo;
        logic [PT_W-1:0]   hi;
    } fetch_t;

    typedef struct packed {
        logic                 vld;
        logic                 byp;
        logic [IN_W-1:0]      raw;
        logic [PT_W-1:0]      base;
        logic [PT_W-1:0]      hi;
        logic signed [SW-1:0] adj;
    } mul_t;

    fetch_t s1;
    mul_t   s2;

    logic [SEG_W:0] idx_lo, idx_hi;
    assign idx_lo = {1'b0, in_code[IN_W-1 -: SEG_W]};
    assign idx_hi = idx_lo + 1'b1;

    // Stage 1: capture both segment endpoints from the current table.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld  <= in_vld;
            s1.byp  <= in_byp;
            s1.raw  <= in_code;
            s1.frac <= in_code[FR_W-1:0];
            s1.lo   <= pts[idx_lo];
            s1.hi   <= pts[idx_hi];
        end
    end

    // Stage 2: signed slope times fraction, round to nearest.
    logic signed [DW-1:0]  diff;
    logic signed [PRW-1:0] prod, rnd;
    assign diff = $signed({1'b0, s1.hi}) - $signed({1'b0, s1.lo});
    assign prod = PRW'(diff) * PRW'($signed({1'b0, s1.frac}));
    assign rnd  = (prod + PRW'(1 << (FR_W - 1))) >>> FR_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld  <= s1.vld;
            s2.byp  <= s1.byp;
            s2.raw  <= s1.raw;
            s2.base <= s1.lo;
            s2.hi   <= s1.hi;
            s2.adj  <= SW'(rnd);
        end
    end

    // Stage 3: accumulate, clamp, select bypass.
    logic signed [SW-1:0] sum;
    logic [PT_W-1:0]      clamped;
    assign sum = $signed({2'b00, s2.base}) + s2.adj;
    always_comb begin
        if (sum[SW-1])        clamped = '0;
        else if (sum[SW-2])   clamped = '1;
        else                  clamped = sum[PT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_val <= '0;
        end else begin
            out_vld <= s2.vld;
            out_val <= s2.byp ? PT_W'(s2.raw) : clamped;
        end
    end

    AST_WITHIN_SEGMENT: assert property (@(posedge clk) disable iff (rst)
        (s2.vld && !s2.byp && s2.hi >= s2.base)
        |=> (out_val >= $past(s2.base) && out_val <= $past(s2.hi))); // R10

    AST_ZERO_FRAC_HITS_POINT: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !$past(s1.byp, 2) && $past(s1.frac, 2) == '0)
        |-> out_val == $past(s1.lo, 2)); // R2

endmodule

// File: rtl/degam_lut.sv
module degam_lut
    import degam_pkg::*;
#(
    parameter int IN_W  = DG_IN_W,
    parameter int SEG_W = DG_SEG_W,
    parameter int PT_W  = DG_PT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W:0]   wr_addr,
    input  logic [PT_W-1:0]  wr_data,
    output logic             mono_err,
    input  logic             bypass,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_r,
    input  logic [IN_W-1:0]  in_g,
    input  logic [IN_W-1:0]  in_b,
    output logic             out_valid,
    output logic [PT_W-1:0]  out_r,
    output logic [PT_W-1:0]  out_g,
    output logic [PT_W-1:0]  out_b
);

    localparam int NPTS = (1 << SEG_W) + 1;
    localparam int AW   = SEG_W + 1;

    logic [NPTS-1:0][PT_W-1:0]     pts;
    logic [DG_LANES-1:0][IN_W-1:0] lane_in;
    logic [DG_LANES-1:0][PT_W-1:0] lane_out;
    logic [DG_LANES-1:0]           lane_vld;

    assign lane_in[LANE_R] = in_r;
    assign lane_in[LANE_G] = in_g;
    assign lane_in[LANE_B] = in_b;

    degam_table #(.SEG_W(SEG_W), .PT_W(PT_W), .AW(AW), .NPTS(NPTS)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pts      (pts),
        .mono_err (mono_err)
    );

    for (genvar gl = 0; gl < DG_LANES; gl++) begin : g_lane
        degam_lane #(.IN_W(IN_W), .SEG_W(SEG_W), .PT_W(PT_W), .NPTS(NPTS)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .pts     (pts),
            .in_vld  (in_valid),
            .in_byp  (bypass),
            .in_code (lane_in[gl]),
            .out_vld (lane_vld[gl]),
            .out_val (lane_out[gl])
        );
    end

    assign out_valid = lane_vld[LANE_R];
    assign out_r     = lane_out[LANE_R];
    assign out_g     = lane_out[LANE_G];
    assign out_b     = lane_out[LANE_B];

    // Cycles since reset, saturating; arms the history-based checks.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_LANES_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (lane_vld == '0) || (lane_vld == '1)); // R4

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> out_valid == $past(in_valid, 3)); // R5

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && $past(bypass, 3))
        |-> (out_r == PT_W'($past(in_r, 3)) && out_b == PT_W'($past(in_b, 3)))); // R6

endmodule

// File: tb/degam_lut_test.sv
module degam_lut_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPTS = 33;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic        mono_err;
    logic        bypass;
    logic        in_valid;
    logic [9:0]  in_r, in_g, in_b;
    logic        out_valid;
    logic [15:0] out_r, out_g, out_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    degam_lut uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mono_err(mono_err), .bypass(bypass), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int    mtbl [NPTS];
    bit    merr;
    bit    ev  [3];
    bit    eb  [3];
    int    ex  [3][3];
    int    ec  [3][3];
    string etag[3];

    function automatic int model_px(input int code, input bit byp);
        int s, f, lo, hi, d, t, r;
        if (byp) return code;
        s = code >> 5;
        f = code & 31;
        lo = mtbl[s];
        hi = mtbl[s + 1];
        d = hi - lo;
        t = (d * f + 16) >>> 5;
        r = lo + t;
        if (r < 0) r = 0;
        if (r > 65535) r = 65535;
        return r;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit b, input int cr, input int cg, input int cb,
                        input bit we, input int wa, input int wd, input string tag);
        int act[3];
        string t;
        @(negedge clk);
        // outputs for the pixel driven three negedges ago
        check("R5", "out_valid", int'(out_valid), int'(ev[2]));
        act[0] = out_r; act[1] = out_g; act[2] = out_b;
        if (ev[2]) begin
            for (int ch = 0; ch < 3; ch++) begin
                if (etag[2] != "")        t = etag[2];
                else if (eb[2])           t = "R6";
                else if (ec[2][ch] == 1023) t = "R3";
                else if (ch == 0)         t = "R2";
                else                      t = "R4";
                check(t, $sformatf("ch%0d code %0d", ch, ec[2][ch]), act[ch], ex[2][ch]);
            end
        end
        check(merr ? "R9" : "R7", "mono_err", int'(mono_err), int'(merr));
        // shift expectation pipe
        for (int k = 2; k > 0; k--) begin
            ev[k] = ev[k-1]; eb[k] = eb[k-1]; etag[k] = etag[k-1];
            for (int ch = 0; ch < 3; ch++) begin
                ex[k][ch] = ex[k-1][ch]; ec[k][ch] = ec[k-1][ch];
            end
        end
        // R8: pixel uses table before this cycle's write
        ev[0] = v; eb[0] = b; etag[0] = tag;
        ec[0][0] = cr; ec[0][1] = cg; ec[0][2] = cb;
        for (int ch = 0; ch < 3; ch++) ex[0][ch] = model_px(ec[0][ch], b);
        if (we && wa < NPTS) begin
            if (wa > 0 && wd < mtbl[wa-1]) merr = 1'b1;
            if (wa < NPTS - 1 && wd > mtbl[wa+1]) merr = 1'b1;
            mtbl[wa] = wd;
        end
        in_valid = v; bypass = b;
        in_r = 10'(cr); in_g = 10'(cg); in_b = 10'(cb);
        wr_en = we; wr_addr = 6'(wa); wr_data = 16'(wd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; bypass = 0; in_valid = 0;
        in_r = 0; in_g = 0; in_b = 0;
        merr = 0;
        for (int i = 0; i < NPTS; i++) mtbl[i] = (i * 2048 > 65535) ? 65535 : i * 2048;
        for (int k = 0; k < 3; k++) begin
            ev[k] = 0; eb[k] = 0; etag[k] = "";
            for (int ch = 0; ch < 3; ch++) begin ex[k][ch] = 0; ec[k][ch] = 0; end
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "out_valid in reset", int'(out_valid), 0);
        check("R9", "mono_err in reset", int'(mono_err), 0);
        check("R9", "out_r in reset", int'(out_r), 0);
        rst = 1'b0;

        // R1/R2/R3/R4: full sweep on the reset curve
        for (int c = 0; c < 1024; c++) step(1, 0, c, c ^ 341, 1023 - c, 0, 0, 0, "");

        // R1: load a quadratic curve in ascending order
        for (int i = 0; i < NPTS; i++)
            step(0, 0, 0, 0, 0, 1, i, (i * i * 64 > 65535) ? 65535 : i * i * 64, "R1");

        // R5/R6: sweep with valid gaps and interleaved bypass
        for (int c = 0; c < 1024; c++)
            step((c % 5) != 4, (c % 7) == 0, c, 1023 - c, (c * 3) & 1023, 0, 0, 0, "");

        // R8: rewrite breakpoint 1 mid-stream
        for (int c = 0; c < 128; c++)
            step(1, 0, c, c, c, c == 40, 1, 200, "R8");

        // R1: out-of-range writes leave the table untouched
        step(0, 0, 0, 0, 0, 1, 40, 0, "R1");
        step(0, 0, 0, 0, 0, 1, 63, 65535, "R1");
        for (int c = 0; c < 1024; c += 3) step(1, 0, c, c, c, 0, 0, 0, "R1");

        // R7: non-monotonic write is flagged and stored
        step(0, 0, 0, 0, 0, 1, 5, 65000, "R7");
        for (int c = 128; c < 224; c++) step(1, 0, c, c, c, 0, 0, 0, "R7");

        // R9: flag stays after a legal write
        step(0, 0, 0, 0, 0, 1, 20, 25600, "R9");
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule